// File: doc/BRIEF.md
# Prescaled 16-bit Down-Counting Timer

This block is a small memory-mapped timer. A 16-bit counter counts down by one on every prescaled tick, where the tick rate is the input clock divided by 1, 16 or 256. When the counter arrives at zero it sets a sticky interrupt flag. On the following tick it either restarts from a programmable reload value (periodic mode) or wraps to 0xFFFF and keeps going (free-running mode).

Software uses a plain strobe interface. One write strobe and one read strobe share a byte address and a 32-bit data bus. Four word locations hold the reload value, the live count (read only), a control word and an interrupt acknowledge. Writing the reload value also restarts the count at once. The interrupt output is the sticky flag gated by an enable bit in the control word.

Top module: `ptimer16`

## Requirements
- R1: After reset the reload value, the count and the control word all read as zero, and `irq` is low.
- R2: Word offsets are decoded from address bits 3:2: 0x0 is the reload value, 0x4 the live count, 0x8 the control word and 0xC the interrupt acknowledge. The reload and count locations read back only their low 16 bits, with the upper bits zero. Writes to 0x4 are ignored. The control word keeps only bits 7, 6, 5, 3 and 2, and the others read as zero. A read of 0xC returns zero.
- R3: A write to offset 0x0 places the low 16 bits of the data into both the reload register and the counter on that clock edge, and restarts the prescaler phase at zero.
- R4: Control bits 3:2 pick the divide ratio: 00 divides by 1, 01 by 16, 10 by 256, and 11 by 1. Once the timer is enabled or reloaded, the counter decrements on every N-th enabled clock edge.
- R5: When control bit 7 is 0, the counter holds its value and the prescaler is held at phase zero.
- R6: A tick that leaves the counter at zero sets the interrupt flag, unless a reload write happens on the same edge.
- R7: When control bit 6 is 1 (periodic), the tick taken while the counter is zero loads the reload value.
- R8: When control bit 6 is 0 (free-running), the tick taken while the counter is zero loads 0xFFFF.
- R9: The interrupt flag stays set until any write to offset 0xC. If a setting event falls on the same edge as the write, the setting event wins.
- R10: The `irq` output is the interrupt flag ANDed with control bit 5. Enabling bit 5 later exposes a flag that was set earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe; rdata is zero while it is low |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
The hardest conditions to reach are the exact tick edges of the slower divide ratios and the zero crossing itself. A decrement under divide-by-256 appears only on the 256th enabled edge after the control write. The flag is set on one edge, and the reload or wrap follows on the next tick. The stimulus reaches these points by counting idle cycles from the edge that enables the timer, then placing two back-to-back reads on either side of the expected tick. The sticky flag is brought out through the interrupt-enable bit: the flag is set while that bit is off, and the bit is switched on afterwards.

// File: rtl/ptimer16.sv
module ptimer16 #(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int DIV_MID_LOG = 4,
  parameter int DIV_HI_LOG  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PRE_W = DIV_HI_LOG;
  localparam logic [1:0] IDX_LOAD = 2'd0;
  localparam logic [1:0] IDX_VAL  = 2'd1;
  localparam logic [1:0] IDX_CTRL = 2'd2;
  localparam logic [1:0] IDX_ACK  = 2'd3;
  localparam int B_RUN  = 7;
  localparam int B_PER  = 6;
  localparam int B_IE   = 5;
  localparam logic [7:0] CTRL_KEEP = 8'hEC;
  localparam logic [PRE_W-1:0] LAST_MID = PRE_W'((1 << DIV_MID_LOG) - 1);
  localparam logic [PRE_W-1:0] LAST_HI  = PRE_W'((1 << DIV_HI_LOG) - 1);

  logic [CNT_W-1:0] load_q, cnt_q;
  logic [7:0]       ctrl_q;
  logic [PRE_W-1:0] pre_q, pre_last;
  logic             flag_q;

  wire [1:0] widx   = addr[3:2];
  wire wr_load      = wr_en && (widx == IDX_LOAD);
  wire wr_ctrl      = wr_en && (widx == IDX_CTRL);
  wire wr_ack       = wr_en && (widx == IDX_ACK);
  wire run          = ctrl_q[B_RUN];
  wire periodic     = ctrl_q[B_PER];

  always_comb begin
    case (ctrl_q[3:2])
      2'b01:   pre_last = LAST_MID;
      2'b10:   pre_last = LAST_HI;
      default: pre_last = '0;
    endcase
  end

  wire tick = run && (pre_q == pre_last);
  wire [CNT_W-1:0] cnt_nxt = (cnt_q == '0) ? (periodic ? load_q : '1) : cnt_q - 1'b1;
  wire hit = tick && (cnt_nxt == '0) && !wr_load;

  always_ff @(posedge clk) begin
    if (!rst_n)                       pre_q <= '0;
    else if (wr_load || !run || tick) pre_q <= '0;
    else                              pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_load) cnt_q <= wdata[CNT_W-1:0];
    else if (tick)    cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       load_q <= '0;
    else if (wr_load) load_q <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata[7:0] & CTRL_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (wr_ack) flag_q <= 1'b0;
  end

  assign irq = flag_q & ctrl_q[B_IE];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (widx)
        IDX_LOAD: rdata[CNT_W-1:0] = load_q;
        IDX_VAL:  rdata[CNT_W-1:0] = cnt_q;
        IDX_CTRL: rdata[7:0]       = ctrl_q;
        default:  rdata            = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptimer16_chk.sv
module ptimer16_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  load_q,
  input logic              tick,
  input logic              run,
  input logic              periodic,
  input logic              flag_q
);
  wire c_load = wr_en && (addr[3:2] == 2'd0);
  wire c_ack  = wr_en && (addr[3:2] == 2'd3);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    c_load |=> cnt_q == $past(wdata[CNT_W-1:0])); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !c_load) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !c_load) |=> $stable(cnt_q)); // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == CNT_W'(1) && !c_load) |=> flag_q); // R6
  AST_PER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && periodic && !c_load) |=> cnt_q == $past(load_q)); // R7
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && !periodic && !c_load) |=> cnt_q == '1); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ack && !tick) |=> !flag_q); // R9
endmodule

bind ptimer16 ptimer16_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt_q(cnt_q), .load_q(load_q), .tick(tick), .run(run),
  .periodic(periodic), .flag_q(flag_q)
);

// File: tb/ptimer16_tb_top.sv
module ptimer16_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  ptimer16 dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rd_en) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard: read with no expected item, actual=%h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(4'h0, 32'h0, "R1 load after reset");
    rd(4'h4, 32'h0, "R1 count after reset");
    rd(4'h8, 32'h0, "R1 ctrl after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // periodic, divide by 1, interrupt enabled
    wr(4'h0, 32'd5);
    wr(4'h8, 32'hE0);
    idle(5);
    chk_irq(1'b1, "R6 flag at zero, R10 gated on");
    rd(4'h4, 32'd0, "R6 count at zero");
    rd(4'h4, 32'd5, "R7 periodic reload");
    wr(4'hC, 32'h0);
    chk_irq(1'b0, "R9 acknowledge clears");

    // free-running, interrupt masked
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd2);
    wr(4'h8, 32'h80);
    idle(2);
    chk_irq(1'b0, "R10 masked irq low");
    rd(4'h4, 32'd0, "R8 count at zero");
    rd(4'h4, 32'hFFFF, "R8 free-run wrap");
    wr(4'h8, 32'hA0);
    chk_irq(1'b1, "R9 sticky flag, R10 late enable");
    wr(4'hC, 32'h0);
    chk_irq(1'b0, "R9 acknowledge in free-run");

    // divide by 16
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd1000);
    wr(4'h8, 32'h84);
    idle(15);
    rd(4'h4, 32'd1000, "R4 div16 before tick");
    rd(4'h4, 32'd999, "R4 div16 after tick");
    idle(8);
    wr(4'h0, 32'd300);
    idle(15);
    rd(4'h4, 32'd300, "R3 reload restarts phase");
    rd(4'h4, 32'd299, "R3 first tick after reload");

    // divide by 256
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd50);
    wr(4'h8, 32'h88);
    idle(255);
    rd(4'h4, 32'd50, "R4 div256 before tick");
    rd(4'h4, 32'd49, "R4 div256 after tick");

    // reserved code acts as divide by 1
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd10);
    wr(4'h8, 32'h8C);
    idle(3);
    rd(4'h4, 32'd7, "R4 reserved ratio");

    // disabled hold and register map
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd77);
    idle(20);
    rd(4'h4, 32'd77, "R5 disabled hold");
    wr(4'h4, 32'h1234);
    rd(4'h4, 32'd77, "R2 count write ignored");
    wr(4'h0, 32'hABCD_1234);
    rd(4'h0, 32'h0000_1234, "R2 load low 16 bits");
    rd(4'h4, 32'h0000_1234, "R3 load sets count");
    wr(4'h0, 32'h0000_FFFF);
    rd(4'h0, 32'h0000_FFFF, "R2 full range load");
    rd(4'h4, 32'h0000_FFFF, "R3 full range count");
    rd(4'hC, 32'h0, "R2 acknowledge reads zero");
    wr(4'h8, 32'hFF);
    rd(4'h8, 32'h0000_00EC, "R2 ctrl kept bits");
    wr(4'h8, 32'h0);
    idle(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule